// File: doc/BRIEF.md
# Processor state image loader

This block restores a full processor context from a fixed image in memory. On a start pulse it becomes a bus master on a 16-bit read port. It fetches a 102-byte image, one word per cycle, starting at physical address 000800h. It scatters each word into a register file. The visible part of that file holds the machine status word, task register, flags, instruction pointer, five selectors and eight general registers. The hidden part holds eight six-byte descriptor caches. The load occupies a fixed 195-cycle window, and completion is flagged only when that window closes.

After a load, the hidden caches govern every segment access. The selectors are never consulted for this. An access names one of four data or code segments and a 16-bit offset. The block flags a fault, with vector 0Dh, when the cache is marked not present or when the offset lies past the cached limit. The current privilege level comes from the privilege field of the code-segment cache.

Writing a selector through the selector port reloads that selector together with its cache. After such a write the two agree again. Read-back ports expose the register file and the caches.

Top module: `state_image_loader`

## Requirements
- R1: After reset, busy_o, done_o and mem_rd_o are 0, every register and cache reads 0, cpl_o is 0, and every access faults, because every valid bit is clear.
- R2: A start accepted at a clock edge causes exactly 51 consecutive read cycles. The first read is issued in the cycle after that edge. Word k is read at address 000800h + 2k, with mem_rdata_i taken in the same cycle.
- R3: busy_o is 1 from the start edge until exactly 195 edges after it. At that edge busy_o falls and done_o rises. done_o then holds until the next accepted start, which clears it at its own edge.
- R4: Words are little-endian. Word 3 loads the status word (register 0). Words 11 to 26 load registers 1 to 16: task register, flags, instruction pointer, LDT selector, DS, SS, CS, ES, DI, SI, BP, SP, BX, DX, CX and AX. Words 0 to 2 and 4 to 10 are discarded.
- R5: Cache c (0 ES, 1 CS, 2 SS, 3 DS, 4 GDT, 5 LDT, 6 IDT, 7 TSS) is loaded from words 27+3c to 29+3c. The first word gives base[15:0]. The second word gives base[23:16] in its low byte and the access byte in its high byte. The third word gives the limit.
- R6: An access through a cache whose access-byte bit 7 is 0 sets acc_fault_o, and acc_vec_o reads 0Dh. Without a fault, acc_vec_o reads 00h.
- R7: An access faults when its offset is greater than the cached limit. An offset equal to the limit is accepted. acc_seg_i uses 0 ES, 1 CS, 2 SS and 3 DS.
- R8: cpl_o equals bits 6:5 of the code-segment cache's access byte.
- R9: Accesses use the caches as loaded, whatever the selectors hold. A selector write that is not issued during a load stores sel_val_i into that selector (ES reg 8, CS 7, SS 6, DS 5) and the supplied base, access byte and limit into its cache, at the same edge.
- R10: A start pulse while busy_o is 1 has no effect. The read sequence and the completion edge keep their original timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load request |
| busy_o | output | 1 | Load window open |
| done_o | output | 1 | Load window closed, held until the next start |
| mem_rd_o | output | 1 | Read strobe |
| mem_addr_o | output | 24 | Byte address of the word being read |
| mem_rdata_i | input | 16 | Read data for mem_addr_o, same cycle |
| sel_wr_i | input | 1 | Selector and cache write |
| sel_seg_i | input | 2 | Segment to write |
| sel_val_i | input | 16 | New selector value |
| sel_base_i | input | 24 | New cache base |
| sel_ar_i | input | 8 | New cache access byte |
| sel_limit_i | input | 16 | New cache limit |
| acc_seg_i | input | 2 | Segment of the access |
| acc_off_i | input | 16 | Offset of the access |
| acc_fault_o | output | 1 | Access fault |
| acc_vec_o | output | 8 | Fault vector, 0Dh or 00h |
| cpl_o | output | 2 | Current privilege level |
| reg_sel_i | input | 5 | Register read-back index |
| reg_q_o | output | 16 | Register read-back value |
| cache_sel_i | input | 3 | Cache read-back index |
| cache_base_o | output | 24 | Cache base |
| cache_ar_o | output | 8 | Cache access byte |
| cache_limit_o | output | 16 | Cache limit |

## Verification
The access checks and cpl_o are combinational from the caches, so they are sampled at the falling edge after their inputs change. Register and cache contents become visible at the falling edge after the edge that wrote them. The bench counts edges from the start edge and samples done_o and busy_o at the falling edges after edges 194 and 195. A falling-edge monitor checks the address and strobe in every cycle of the 51-word fetch.

// File: rtl/img_ld_pkg.sv
package img_ld_pkg;

    localparam int IMG_WORDS   = 51;
    localparam int NUM_VIS     = 17;
    localparam int NUM_CACHE   = 8;
    localparam int NUM_SEG     = 4;
    localparam int WORD_MSW    = 3;
    localparam int WORD_VIS_LO = 11;
    localparam int WORD_VIS_HI = 26;
    localparam int WORD_CACHE0 = 27;
    localparam int AR_VALID    = 7;
    localparam logic [7:0] FAULT_VEC = 8'h0D;

    typedef struct packed {
        logic [23:0] base;
        logic [7:0]  ar;
        logic [15:0] limit;
    } desc_t;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_FETCH,
        LD_HOLD,
        LD_DONE
    } ld_state_e;

    function automatic logic word_is_vis(input logic [5:0] k);
        return (k == 6'(WORD_MSW)) || (k >= 6'(WORD_VIS_LO) && k <= 6'(WORD_VIS_HI));
    endfunction

    function automatic logic [4:0] word_vis_slot(input logic [5:0] k);
        return (k == 6'(WORD_MSW)) ? 5'd0 : 5'(k - 6'd10);
    endfunction

    // ES->8, CS->7, SS->6, DS->5
    function automatic logic [4:0] seg_vis_slot(input logic [1:0] s);
        return 5'd8 - {3'd0, s};
    endfunction

endpackage

// File: rtl/img_ld_seq.sv
module img_ld_seq
    import img_ld_pkg::*;
#(
    parameter int          ADDR_W      = 24,
    parameter logic [23:0] BASE_ADDR   = 24'h000800,
    parameter int          LOAD_CYCLES = 195,
    localparam int         CNT_W       = $clog2(LOAD_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              rd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [5:0]        word_o
);

    ld_state_e        state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LD_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                LD_IDLE, LD_DONE: begin
                    if (start_i) begin
                        state <= LD_FETCH;
                        cnt   <= '0;
                    end
                end
                LD_FETCH: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(IMG_WORDS - 1)) state <= LD_HOLD;
                end
                LD_HOLD: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(LOAD_CYCLES - 1)) state <= LD_DONE;
                end
                default: state <= LD_IDLE;
            endcase
        end
    end

    assign busy_o = (state == LD_FETCH) || (state == LD_HOLD);
    assign done_o = (state == LD_DONE);
    assign rd_o   = (state == LD_FETCH);
    assign addr_o = ADDR_W'(BASE_ADDR) + ADDR_W'({cnt, 1'b0});
    assign word_o = cnt[5:0];

endmodule

// File: rtl/img_ld_regs.sv
module img_ld_regs
    import img_ld_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ld_we,
    input  logic [5:0]  ld_word,
    input  logic [15:0] ld_data,
    input  logic        sel_we,
    input  logic [1:0]  sel_seg,
    input  logic [15:0] sel_val,
    input  desc_t       sel_desc,
    input  logic [4:0]  reg_sel,
    output logic [15:0] reg_q,
    input  logic [2:0]  cache_sel,
    output desc_t       cache_q,
    input  logic [1:0]  acc_seg,
    output desc_t       acc_desc,
    output desc_t       cs_desc
);

    logic [15:0] vis [NUM_VIS];
    desc_t       cache [NUM_CACHE];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_VIS; i++) vis[i] <= '0;
        end else begin
            if (ld_we && word_is_vis(ld_word)) vis[word_vis_slot(ld_word)] <= ld_data;
            if (sel_we) vis[seg_vis_slot(sel_seg)] <= sel_val;
        end
    end

    for (genvar g = 0; g < NUM_CACHE; g++) begin : g_cache
        localparam logic [5:0] W0 = 6'(WORD_CACHE0 + 3 * g);
        desc_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (ld_we && ld_word == W0) begin
                q.base[15:0] <= ld_data;
            end else if (ld_we && ld_word == W0 + 6'd1) begin
                q.base[23:16] <= ld_data[7:0];
                q.ar          <= ld_data[15:8];
            end else if (ld_we && ld_word == W0 + 6'd2) begin
                q.limit <= ld_data;
            end else if (g < NUM_SEG && sel_we && {1'b0, sel_seg} == 3'(g)) begin
                q <= sel_desc;
            end
        end
        assign cache[g] = q;
    end

    assign reg_q    = (reg_sel < 5'(NUM_VIS)) ? vis[reg_sel] : 16'h0000;
    assign cache_q  = cache[cache_sel];
    assign acc_desc = cache[{1'b0, acc_seg}];
    assign cs_desc  = cache[SEG_CS];

endmodule

// File: rtl/img_ld_guard.sv
module img_ld_guard
    import img_ld_pkg::*;
(
    input  desc_t       desc,
    input  logic [15:0] offset,
    output logic        fault,
    output logic [7:0]  vec
);

    logic absent;
    logic over;

    always_comb begin
        absent = ~desc.ar[AR_VALID];
        over   = offset > desc.limit;
        fault  = absent | over;
        vec    = fault ? FAULT_VEC : 8'h00;
    end

endmodule

// File: rtl/state_image_loader.sv
module state_image_loader
    import img_ld_pkg::*;
#(
    parameter int          ADDR_W      = 24,
    parameter logic [23:0] BASE_ADDR   = 24'h000800,
    parameter int          LOAD_CYCLES = 195
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [15:0]       mem_rdata_i,
    input  logic              sel_wr_i,
    input  logic [1:0]        sel_seg_i,
    input  logic [15:0]       sel_val_i,
    input  logic [23:0]       sel_base_i,
    input  logic [7:0]        sel_ar_i,
    input  logic [15:0]       sel_limit_i,
    input  logic [1:0]        acc_seg_i,
    input  logic [15:0]       acc_off_i,
    output logic              acc_fault_o,
    output logic [7:0]        acc_vec_o,
    output logic [1:0]        cpl_o,
    input  logic [4:0]        reg_sel_i,
    output logic [15:0]       reg_q_o,
    input  logic [2:0]        cache_sel_i,
    output logic [23:0]       cache_base_o,
    output logic [7:0]        cache_ar_o,
    output logic [15:0]       cache_limit_o
);

    logic [5:0] word;
    desc_t      sel_desc, cache_q, acc_desc, cs_desc;

    img_ld_seq #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .LOAD_CYCLES(LOAD_CYCLES)
    ) u_seq (
        .clk(clk), .rst(rst), .start_i(start_i),
        .busy_o(busy_o), .done_o(done_o), .rd_o(mem_rd_o),
        .addr_o(mem_addr_o), .word_o(word)
    );

    assign sel_desc = '{base: sel_base_i, ar: sel_ar_i, limit: sel_limit_i};

    img_ld_regs u_regs (
        .clk(clk), .rst(rst),
        .ld_we(mem_rd_o), .ld_word(word), .ld_data(mem_rdata_i),
        .sel_we(sel_wr_i & ~busy_o), .sel_seg(sel_seg_i),
        .sel_val(sel_val_i), .sel_desc(sel_desc),
        .reg_sel(reg_sel_i), .reg_q(reg_q_o),
        .cache_sel(cache_sel_i), .cache_q(cache_q),
        .acc_seg(acc_seg_i), .acc_desc(acc_desc), .cs_desc(cs_desc)
    );

    img_ld_guard u_guard (
        .desc(acc_desc), .offset(acc_off_i),
        .fault(acc_fault_o), .vec(acc_vec_o)
    );

    assign cpl_o         = cs_desc.ar[6:5];
    assign cache_base_o  = cache_q.base;
    assign cache_ar_o    = cache_q.ar;
    assign cache_limit_o = cache_q.limit;

endmodule

// File: rtl/img_ld_chk.sv
module img_ld_chk #(
    parameter int ADDR_W      = 24,
    parameter int LOAD_CYCLES = 195
) (
    input logic              clk,
    input logic              rst,
    input logic              busy_o,
    input logic              done_o,
    input logic              mem_rd_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              acc_fault_o,
    input logic [7:0]        acc_vec_o
);

    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)         run_len <= '0;
        else if (busy_o) run_len <= run_len + 16'd1;
        else             run_len <= '0;
    end

    a_r2_rd_within_busy: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> busy_o);

    a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && $past(mem_rd_o)) |-> mem_addr_o == $past(mem_addr_o) + ADDR_W'(2));

    a_r3_done_excl_busy: assert property (@(posedge clk) disable iff (rst)
        !(done_o && busy_o));

    a_r3_window_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> run_len == 16'(LOAD_CYCLES));

    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(busy_o));

    a_r6_vec_code: assert property (@(posedge clk) disable iff (rst)
        acc_vec_o == (acc_fault_o ? 8'h0D : 8'h00));

endmodule

bind state_image_loader img_ld_chk #(
    .ADDR_W(ADDR_W), .LOAD_CYCLES(LOAD_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .busy_o(busy_o), .done_o(done_o),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .acc_fault_o(acc_fault_o), .acc_vec_o(acc_vec_o)
);

// File: tb/test_state_image_loader.sv
module test_state_image_loader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        busy_o, done_o, mem_rd_o;
    logic [23:0] mem_addr_o;
    logic [15:0] mem_rdata_i;
    logic        sel_wr_i = 1'b0;
    logic [1:0]  sel_seg_i = '0;
    logic [15:0] sel_val_i = '0;
    logic [23:0] sel_base_i = '0;
    logic [7:0]  sel_ar_i = '0;
    logic [15:0] sel_limit_i = '0;
    logic [1:0]  acc_seg_i = '0;
    logic [15:0] acc_off_i = '0;
    logic        acc_fault_o;
    logic [7:0]  acc_vec_o;
    logic [1:0]  cpl_o;
    logic [4:0]  reg_sel_i = '0;
    logic [15:0] reg_q_o;
    logic [2:0]  cache_sel_i = '0;
    logic [23:0] cache_base_o;
    logic [7:0]  cache_ar_o;
    logic [15:0] cache_limit_o;

    always #10 clk = ~clk;

    logic [15:0] img [51];
    int n_run = 0, n_fail = 0;
    int n_reads = 0, addr_err = 0;
    logic finished = 1'b0;

    // image word index from byte address, out-of-window reads return a marker
    logic [23:0] rel;
    assign rel = mem_addr_o - 24'h000800;
    assign mem_rdata_i = (rel < 24'd102) ? img[rel[6:1]] : 16'hDEAD;

    state_image_loader i_state_image_loader (.*);

    // { seg[1:0], offset[15:0], expected fault }
    localparam logic [18:0] ACC_VEC [8] = '{
        {2'd0, 16'h00FF, 1'b0}, {2'd0, 16'h0100, 1'b1},
        {2'd0, 16'h0000, 1'b0}, {2'd1, 16'h1000, 1'b0},
        {2'd1, 16'h1001, 1'b1}, {2'd2, 16'h0000, 1'b0},
        {2'd2, 16'h0001, 1'b1}, {2'd3, 16'h0000, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && mem_rd_o) begin
            if (mem_addr_o !== 24'h000800 + 24'(2 * n_reads)) addr_err++;
            n_reads++;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 51; k++) img[k] = 16'(k * 16'h0301 + 16'h1000);
        img[27] = 16'h3456; img[28] = 16'h9212; img[29] = 16'h00FF;
        img[30] = 16'h0000; img[31] = 16'hFA01; img[32] = 16'h1000;
        img[33] = 16'h2000; img[34] = 16'hF201; img[35] = 16'h0000;
        img[36] = 16'h4000; img[37] = 16'h1203; img[38] = 16'hFFFF;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 done", 32'(done_o), 0);
        chk("R1 rd", 32'(mem_rd_o), 0);
        chk("R1 cpl", 32'(cpl_o), 0);
        reg_sel_i = 5'd8; cache_sel_i = 3'd1;
        #1;
        chk("R1 reg", 32'(reg_q_o), 0);
        chk("R1 cache ar", 32'(cache_ar_o), 0);
        chk("R1 fault", 32'(acc_fault_o), 1);

        // start: sampled at edge E0
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk) start_i = 1'b0;
        chk("R3 busy after start", 32'(busy_o), 1);
        for (int c = 1; c <= 195; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c == 50) start_i = 1'b1;   // R10 start while busy
            if (c == 51) start_i = 1'b0;
            if (c == 194) begin
                chk("R3 done early", 32'(done_o), 0);
                chk("R10 busy kept", 32'(busy_o), 1);
            end
            if (c == 195) begin
                chk("R3 done at 195", 32'(done_o), 1);
                chk("R3 busy cleared", 32'(busy_o), 0);
            end
        end
        chk("R2 read count", 32'(n_reads), 51);
        chk("R2 address errors", 32'(addr_err), 0);

        // R4 visible registers
        for (int r = 0; r < 17; r++) begin
            reg_sel_i = 5'(r);
            #1;
            chk("R4 register", 32'(reg_q_o), 32'(img[(r == 0) ? 3 : r + 10]));
        end
        reg_sel_i = 5'd17;
        #1;
        chk("R4 unused index", 32'(reg_q_o), 0);

        // R5 caches
        for (int c = 0; c < 8; c++) begin
            cache_sel_i = 3'(c);
            #1;
            chk("R5 base", 32'(cache_base_o), 32'({img[28 + 3 * c][7:0], img[27 + 3 * c]}));
            chk("R5 ar", 32'(cache_ar_o), 32'(img[28 + 3 * c][15:8]));
            chk("R5 limit", 32'(cache_limit_o), 32'(img[29 + 3 * c]));
        end

        chk("R8 cpl from CS", 32'(cpl_o), 3);

        // R6/R7/R9: caches govern access regardless of selector values
        for (int v = 0; v < 8; v++) begin
            acc_seg_i = ACC_VEC[v][18:17];
            acc_off_i = ACC_VEC[v][16:1];
            #1;
            chk(ACC_VEC[v][18:17] == 2'd3 ? "R6 invalid fault" : "R7 limit fault",
                32'(acc_fault_o), 32'(ACC_VEC[v][0]));
            chk("R6 vector", 32'(acc_vec_o), ACC_VEC[v][0] ? 32'h0D : 32'h00);
        end

        // R9 selector write refreshes selector and cache
        @(negedge clk);
        sel_wr_i = 1'b1; sel_seg_i = 2'd0; sel_val_i = 16'h0040;
        sel_base_i = 24'h000100; sel_ar_i = 8'h80; sel_limit_i = 16'h0010;
        @(posedge clk);
        @(negedge clk) sel_wr_i = 1'b0;
        reg_sel_i = 5'd8; cache_sel_i = 3'd0; acc_seg_i = 2'd0; acc_off_i = 16'h0011;
        #1;
        chk("R9 selector", 32'(reg_q_o), 32'h0040);
        chk("R9 cache base", 32'(cache_base_o), 32'h000100);
        chk("R9 cache limit", 32'(cache_limit_o), 32'h0010);
        chk("R9 new limit fault", 32'(acc_fault_o), 1);
        acc_off_i = 16'h0010;
        #1;
        chk("R9 new limit ok", 32'(acc_fault_o), 0);

        sel_wr_i = 1'b1; sel_seg_i = 2'd1; sel_val_i = 16'h0008;
        sel_base_i = 24'h0; sel_ar_i = 8'hA0; sel_limit_i = 16'hFFFF;
        @(posedge clk);
        @(negedge clk) sel_wr_i = 1'b0;
        chk("R8 cpl after CS write", 32'(cpl_o), 1);

        // R3 restart clears done
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk) start_i = 1'b0;
        chk("R3 done cleared", 32'(done_o), 0);
        chk("R3 busy on restart", 32'(busy_o), 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule